// File: doc/BRIEF.md
# Clock Gear Divider Controller

This block turns one oscillator clock into two single-cycle clock-enable streams, one for a processor domain and one for a peripheral domain. Both streams stay in the oscillator domain, so the logic they drive keeps the oscillator as its clock and advances only on cycles where its enable is high. An eight-bit gear register sets the rates. It has a simple write port and continuous read-back. One bit of the register picks the source rate, either the full oscillator rate or half of it. Two two-bit fields then slow the source by 1, 2, 4 or 8, and each domain has its own field.

Every enable is derived from one free-running cycle counter that starts at zero when reset is released. A domain whose period is P cycles fires on every cycle where the count modulo P equals P-1. A new register value is not applied at once. It is applied to both domains together, at the first cycle where the old and the new enables of both domains all fire. A rate change therefore never produces an enable period shorter or longer than one of the two settings involved.

Top module: `gear_clk_ctrl`

## Requirements
- R1: While reset is held, and afterwards until a write occurs, the register reads 8'hFC. That value gives processor field 11, peripheral field 11 and the full-rate source. Both enables are low on cycles 0 to 6 counted from reset release, and both are high on cycle 7.
- R2: A write stores all eight bits of the data at the clock edge that samples it. The stored value appears on the read port from the next cycle.
- R3: Register bit 0 selects the source: 0 gives the full oscillator rate and 1 gives half the oscillator rate. This bit doubles the period of both domains.
- R4: Register bits 7:6 set the processor divisor against the source: 00 gives 1, 01 gives 2, 10 gives 4, 11 gives 8.
- R5: Register bits 3:2 set the peripheral divisor, with the same encoding as R4.
- R6: The two domain divisors are independent, so any pair of field values yields its own period in each domain.
- R7: A domain with period P = (1 + bit0) * 2^field is high for exactly one cycle in every P. It fires on the cycles where the count since reset release, modulo P, equals P-1. With P = 1 the enable stays high.
- R8: A new register value takes effect in both domains on the same cycle. That cycle follows the first cycle where the old and the new enables of both domains all fire. Every interval between consecutive pulses equals the period of the setting that is active right after the first of the two pulses.
- R9: Register bits 5:4 and bit 1 are stored and read back, but they do not affect either enable.
- R10: When the write strobe is low, the register keeps its value whatever the write data are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Current register contents |
| cpu_en | output | 1 | Processor-domain clock enable |
| per_en | output | 1 | Peripheral-domain clock enable |

## Verification
A written value shows on the read port one cycle after the edge that samples the strobe. The enables are combinational functions of the registered counter and the active setting. A new setting therefore shapes the enables starting in the cycle after the commit edge, which is never more than sixteen cycles after the write. The bench runs a behavioural model that advances on each rising edge and compares every output at the following falling edge. The model also tracks the interval between pulses and checks it against the period that is active right after each pulse. The sweep over all source and field combinations measures intervals only after forty cycles of settling, so every pending commit has landed before the measurement starts.

// File: rtl/gear_pkg.sv
package gear_pkg;
   // Number of enable domains served by the controller.
   localparam int unsigned GEAR_DOMAINS = 2;

   // Index of each domain in the per-domain arrays.
   typedef enum logic [0:0] {
      DOM_CPU = 1'b0,
      DOM_PER = 1'b1
   } gear_dom_e;
endpackage

// File: rtl/gear_regfile.sv
module gear_regfile #(
   parameter int unsigned          REG_W   = 8,
   parameter logic [REG_W-1:0]     RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= RST_VAL;
      else if (wr_en) q <= wr_data;
   end

   // R2
   wr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (q == $past(wr_data)));

   // R10
   wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(q));
endmodule

// File: rtl/gear_sequencer.sv
module gear_sequencer #(
   parameter int unsigned LOG_W      = 3,
   parameter int unsigned CNT_W      = 4,
   parameter int unsigned RST_LG_CPU = 3,
   parameter int unsigned RST_LG_PER = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LOG_W-1:0] new_lg_cpu,
   input  logic [LOG_W-1:0] new_lg_per,
   output logic [CNT_W-1:0] cnt,
   output logic [LOG_W-1:0] lg_cpu,
   output logic [LOG_W-1:0] lg_per,
   output logic             commit
);
   logic [LOG_W-1:0] lg_max;
   logic [CNT_W-1:0] span;

   // Longest period among old and new settings of both domains.
   always_comb begin
      lg_max = lg_cpu;
      if (lg_per     > lg_max) lg_max = lg_per;
      if (new_lg_cpu > lg_max) lg_max = new_lg_cpu;
      if (new_lg_per > lg_max) lg_max = new_lg_per;
      span   = ~({CNT_W{1'b1}} << lg_max);
      commit = ((cnt & span) == span);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         lg_cpu <= LOG_W'(RST_LG_CPU);
         lg_per <= LOG_W'(RST_LG_PER);
      end else begin
         cnt <= cnt + 1'b1;
         if (commit) begin
            lg_cpu <= new_lg_cpu;
            lg_per <= new_lg_per;
         end
      end
   end

   // R8
   stay_between_commits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> (lg_cpu == $past(lg_cpu)) && (lg_per == $past(lg_per)));
endmodule

// File: rtl/gear_tap.sv
module gear_tap #(
   parameter int unsigned LOG_W = 3,
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt,
   input  logic [LOG_W-1:0] lg,
   input  logic             hold,
   output logic             en
);
   logic [CNT_W-1:0] mask;

   always_comb begin
      mask = ~({CNT_W{1'b1}} << lg);
      en   = ((cnt & mask) == mask);
   end

   // R7
   single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && (lg != '0) && !hold) |=> !en);
endmodule

// File: rtl/gear_clk_ctrl.sv
module gear_clk_ctrl #(
   parameter int unsigned      REG_W    = 8,
   parameter int unsigned      RATIO_W  = 2,
   parameter int unsigned      CPU_LSB  = 6,
   parameter int unsigned      PER_LSB  = 2,
   parameter int unsigned      SRC_BIT  = 0,
   parameter bit               HALF_SRC = 1'b1,
   parameter logic [REG_W-1:0] RST_VAL  = 8'hFC
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] rd_data,
   output logic             cpu_en,
   output logic             per_en
);
   import gear_pkg::*;

   localparam int unsigned MAX_LG = (1 << RATIO_W) - 1 + (HALF_SRC ? 1 : 0);
   localparam int unsigned LOG_W  = $clog2(MAX_LG + 1);
   localparam int unsigned CNT_W  = (MAX_LG > 0) ? MAX_LG : 1;
   localparam int unsigned RST_LG_CPU = (HALF_SRC ? int'(RST_VAL[SRC_BIT]) : 0)
                                        + int'(RST_VAL[CPU_LSB +: RATIO_W]);
   localparam int unsigned RST_LG_PER = (HALF_SRC ? int'(RST_VAL[SRC_BIT]) : 0)
                                        + int'(RST_VAL[PER_LSB +: RATIO_W]);

   generate
      if (CPU_LSB + RATIO_W > REG_W || PER_LSB + RATIO_W > REG_W || SRC_BIT >= REG_W)
         $error("gear_clk_ctrl: field outside register");
      if (RATIO_W == 0)
         $error("gear_clk_ctrl: ratio field needs a width");
   endgenerate

   logic [REG_W-1:0] reg_q;
   logic             sel_half;
   logic [LOG_W-1:0] new_lg_cpu, new_lg_per, lg_cpu, lg_per;
   logic [CNT_W-1:0] cnt;
   logic             commit;
   logic [LOG_W-1:0] dom_lg [GEAR_DOMAINS];
   logic [GEAR_DOMAINS-1:0] dom_en;

   gear_regfile #(.REG_W(REG_W), .RST_VAL(RST_VAL)) i_regfile (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .q(reg_q)
   );

   // Source selector variant: with the half-rate option removed the bit is inert.
   generate
      if (HALF_SRC) begin : g_src_sel
         assign sel_half = reg_q[SRC_BIT];
      end else begin : g_src_fixed
         assign sel_half = 1'b0;
      end
   endgenerate

   assign new_lg_cpu = LOG_W'(sel_half) + LOG_W'(reg_q[CPU_LSB +: RATIO_W]);
   assign new_lg_per = LOG_W'(sel_half) + LOG_W'(reg_q[PER_LSB +: RATIO_W]);

   gear_sequencer #(
      .LOG_W(LOG_W), .CNT_W(CNT_W),
      .RST_LG_CPU(RST_LG_CPU), .RST_LG_PER(RST_LG_PER)
   ) i_sequencer (
      .clk(clk), .rst_n(rst_n),
      .new_lg_cpu(new_lg_cpu), .new_lg_per(new_lg_per),
      .cnt(cnt), .lg_cpu(lg_cpu), .lg_per(lg_per), .commit(commit)
   );

   assign dom_lg[DOM_CPU] = lg_cpu;
   assign dom_lg[DOM_PER] = lg_per;

   generate
      for (genvar d = 0; d < GEAR_DOMAINS; d++) begin : g_dom
         gear_tap #(.LOG_W(LOG_W), .CNT_W(CNT_W)) i_tap (
            .clk(clk), .rst_n(rst_n), .cnt(cnt), .lg(dom_lg[d]),
            .hold(commit), .en(dom_en[d])
         );
      end
   endgenerate

   assign rd_data = reg_q;
   assign cpu_en  = dom_en[DOM_CPU];
   assign per_en  = dom_en[DOM_PER];

   // R8
   switch_on_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((lg_cpu != $past(lg_cpu)) || (lg_per != $past(lg_per))) |-> $past(cpu_en && per_en));

   // R7
   unity_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lg_cpu == '0) |-> cpu_en);

   // R7
   unity_per_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lg_per == '0) |-> per_en);
endmodule

// File: tb/test_gear_clk_ctrl.sv
module test_gear_clk_ctrl;
   localparam time CLK_PERIOD = 10ns;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       wr_en;
   logic [7:0] wr_data;
   logic [7:0] rd_data;
   logic       cpu_en, per_en;

   int nchk = 0;
   int nerr = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   gear_clk_ctrl i_gear_clk_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .cpu_en(cpu_en), .per_en(per_en)
   );

   function automatic void chk(input bit ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endfunction

   // Behavioural reference model.
   int m_reg, m_cyc, m_lc, m_lp;

   function automatic int lg_of(input int r, input int sh);
      return (r & 1) + ((r >> sh) & 3);
   endfunction

   function automatic bit fires(input int cyc, input int l);
      return (cyc % (1 << l)) == ((1 << l) - 1);
   endfunction

   function automatic bit boundary_now();
      int mx;
      mx = m_lc;
      if (m_lp > mx) mx = m_lp;
      if (lg_of(m_reg, 6) > mx) mx = lg_of(m_reg, 6);
      if (lg_of(m_reg, 2) > mx) mx = lg_of(m_reg, 2);
      return fires(m_cyc, mx);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_reg = 8'hFC; m_cyc = 0; m_lc = 3; m_lp = 3;
      end else begin
         if (boundary_now()) begin
            m_lc = lg_of(m_reg, 6);
            m_lp = lg_of(m_reg, 2);
         end
         if (wr_en) m_reg = wr_data;
         m_cyc++;
      end
   end

   // Per-cycle comparison and pulse interval monitor.
   int  last_c, last_p, exp_gc, exp_gp;
   bit  have_c, have_p;

   always @(negedge clk) begin
      if (!rst_n) begin
         have_c = 0; have_p = 0;
      end else begin
         bit b;
         b = boundary_now();
         chk(rd_data == m_reg[7:0], "R2 R10 read-back", rd_data, m_reg);
         chk(cpu_en == fires(m_cyc, m_lc), "R7 R4 cpu enable", cpu_en, fires(m_cyc, m_lc));
         chk(per_en == fires(m_cyc, m_lp), "R7 R5 per enable", per_en, fires(m_cyc, m_lp));
         if (cpu_en) begin
            if (have_c) chk(m_cyc - last_c == exp_gc, "R8 cpu interval", m_cyc - last_c, exp_gc);
            have_c = 1; last_c = m_cyc;
            exp_gc = 1 << (b ? lg_of(m_reg, 6) : m_lc);
         end
         if (per_en) begin
            if (have_p) chk(m_cyc - last_p == exp_gp, "R8 per interval", m_cyc - last_p, exp_gp);
            have_p = 1; last_p = m_cyc;
            exp_gp = 1 << (b ? lg_of(m_reg, 2) : m_lp);
         end
      end
   end

   task automatic wr(input logic [7:0] v);
      wr_en = 1'b1; wr_data = v;
      @(negedge clk);
      wr_en = 1'b0; wr_data = 8'hA5;
   endtask

   task automatic gap_of(input bit per, output int g);
      int guard = 0;
      g = 0;
      while (!(per ? per_en : cpu_en) && guard < 64) begin
         @(negedge clk); guard++;
      end
      do begin
         @(negedge clk); g++;
      end while (!(per ? per_en : cpu_en) && g < 64);
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      chk(1'b0, "watchdog", 0, 1);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      int g;
      rst_n = 1'b0; wr_en = 1'b0; wr_data = 8'h00;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(rd_data == 8'hFC, "R1 reset value", rd_data, 8'hFC);
      chk(!cpu_en && !per_en, "R1 enables low in reset", {cpu_en, per_en}, 0);
      rst_n = 1'b1;
      repeat (6) @(negedge clk);
      chk(!cpu_en && !per_en, "R1 quiet before cycle 7", {cpu_en, per_en}, 0);
      @(negedge clk);
      chk(cpu_en && per_en, "R1 first pulse at cycle 7", {cpu_en, per_en}, 3);

      // R2 write and read-back
      wr(8'h7A);
      chk(rd_data == 8'h7A, "R2 stored byte", rd_data, 8'h7A);
      // R10 no strobe, data ignored
      wr_data = 8'h55;
      repeat (5) @(negedge clk);
      chk(rd_data == 8'h7A, "R10 hold without strobe", rd_data, 8'h7A);

      // R6 independent ratios: cpu /2, per /4
      repeat (40) @(negedge clk);
      gap_of(1'b0, g); chk(g == 2, "R6 cpu half of source", g, 2);
      gap_of(1'b1, g); chk(g == 4, "R6 per quarter of source", g, 4);

      // R9 inert bits: 0x32 behaves as 0x00
      wr(8'h32);
      repeat (40) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         chk(cpu_en && per_en, "R9 inert bits, continuous enables", {cpu_en, per_en}, 3);
         @(negedge clk);
      end
      chk(rd_data == 8'h32, "R9 inert bits read back", rd_data, 8'h32);

      // R8 abrupt changes between extremes
      wr(8'h00); repeat (3) @(negedge clk);
      wr(8'hFD); repeat (5) @(negedge clk);
      wr(8'h01); repeat (37) @(negedge clk);
      gap_of(1'b0, g); chk(g == 2, "R3 R8 half source unity field", g, 2);

      // R3 R4 R5 sweep over all combinations
      for (int s = 0; s < 2; s++)
         for (int c = 0; c < 4; c++)
            for (int p = 0; p < 4; p++) begin
               wr(8'((c << 6) | (p << 2) | s));
               repeat (40) @(negedge clk);
               gap_of(1'b0, g); chk(g == ((1 + s) << c), "R3 R4 cpu period", g, (1 + s) << c);
               gap_of(1'b1, g); chk(g == ((1 + s) << p), "R3 R5 per period", g, (1 + s) << p);
            end

      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule